// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a 32-bit integer datapath that performs clamped arithmetic and keeps one sticky overflow flag. It covers signed add and subtract, signed doubling, unsigned add and subtract, and saturation of a value to a selectable bit width, both on the whole word and on two independent 16-bit halves. A further add mode reports signed overflow in the flag but returns the wrapped sum.

Each operation is launched by a one-cycle `valid_i` strobe. The result and the flag are registered and appear one clock edge later. Any operation that saturates or overflows raises the flag, and the flag stays high until software-side logic pulses `clr_i`. The flag therefore gathers overflow events across a whole run of operations.

Top module: `sat_alu`

## Requirements
- R1: After reset is released, `res_o` is 0 and `flag_o` is 0.
- R2: Opcode 0 (add with flag) returns the wrapped 32-bit sum of `a_i` and `b_i`. The operation saturates when both operands have the same sign and the sum's sign differs from `a_i`.
- R3: Opcode 1 (signed add) and opcode 2 (signed subtract `a_i - b_i`) detect signed overflow. For subtract, overflow means the operand signs differ and the result's sign differs from `a_i`. On overflow the result is 0x7FFFFFFF if `a_i` is non-negative and 0x80000000 if it is negative; otherwise the exact result is returned.
- R4: Opcode 3 (double `a_i`) returns 0x7FFFFFFF when signed `a_i` >= 0x40000000 and 0x80000000 when signed `a_i` <= 0xC0000000. Both of these cases saturate. Otherwise it returns `a_i` shifted left by one.
- R5: Opcode 4 (unsigned add) returns all-ones and saturates when the true sum exceeds 32 bits. Opcode 5 (unsigned subtract) returns 0 and saturates when `b_i` > `a_i`.
- R6: Opcode 6 (signed width clamp) takes `v` = signed `a_i` and `s` = `shift_i`. If `v` > 2^s-1 it returns 2^s-1. If `v` < -2^s it returns -2^s. In both of those cases it saturates; otherwise it returns `v`.
- R7: Opcode 7 (unsigned width clamp) returns 0 if signed `a_i` is negative and 2^s-1 if `a_i` is above 2^s-1. In both of those cases it saturates; otherwise it returns `a_i`.
- R8: Opcodes 8 and 9 apply the R6 and R7 rules, respectively, to each sign-extended 16-bit half of `a_i`. The two results are packed back into the matching halves. The operation saturates if either half saturates.
- R9: A valid operation that saturates sets `flag_o` at the next edge. A valid operation that does not saturate never clears it.
- R10: `clr_i` clears `flag_o` at the next edge, whether or not `valid_i` is high. If a saturating valid operation occurs in the same cycle, the flag is set instead.
- R11: While `valid_i` is low, `res_o` holds its value and only `clr_i` can change `flag_o`.
- R12: Opcodes 10 to 15 load a result of 0 and never saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Launch an operation this cycle |
| clr_i | input | 1 | Clear the sticky flag |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand or value to clamp |
| b_i | input | 32 | Second operand |
| shift_i | input | 5 | Clamp width `s` for opcodes 6 to 9 |
| res_o | output | 32 | Registered result |
| flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `valid_i`, `clr_i` and `op_i` carry known values in every cycle after reset. They also assume that the internal saturation indication of the combinational datapath is stable when the clock edge samples it. The bench keeps to this by driving every input only on the falling clock edge, so each operation has settled half a period before the edge that registers it. The random stimulus takes operands from a mix of extreme values (the sign boundary, ±2^30, all-ones) and arbitrary words, and draws `shift_i` from its full 0 to 31 range.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_ADD_FLAG = 4'd0,
    OP_ADD_SAT  = 4'd1,
    OP_SUB_SAT  = 4'd2,
    OP_DBL_SAT  = 4'd3,
    OP_UADD_SAT = 4'd4,
    OP_USUB_SAT = 4'd5,
    OP_SCLAMP   = 4'd6,
    OP_UCLAMP   = 4'd7,
    OP_SCLAMP2  = 4'd8,
    OP_UCLAMP2  = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          uns_i,
  input  logic          clamp_i,
  output logic [DW-1:0] res_o,
  output logic          sat_o
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0]   ext;
  logic [DW-1:0] sum;
  logic          s_ovf, u_ovf;

  // carry/borrow out of the zero-extended path gives unsigned overflow
  assign ext   = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
  assign sum   = ext[DW-1:0];
  assign u_ovf = ext[DW];
  assign s_ovf = sub_i ? ((a_i[MSB] ^ b_i[MSB]) & (sum[MSB] ^ a_i[MSB]))
                       : (~(a_i[MSB] ^ b_i[MSB]) & (sum[MSB] ^ a_i[MSB]));
  assign sat_o = uns_i ? u_ovf : s_ovf;

  always_comb begin
    res_o = sum;
    if (sat_o && clamp_i) begin
      if (uns_i) res_o = sub_i ? '0 : '1;
      else       res_o = a_i[MSB] ? SMIN : SMAX;
    end
  end
endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  output logic [DW-1:0] res_o,
  output logic          sat_o
);
  localparam logic signed [DW-1:0] HI   = DW'(1) <<< (DW - 2);
  localparam logic signed [DW-1:0] LO   = -HI;
  localparam logic [DW-1:0]        SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0]        SMIN = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    if ($signed(a_i) >= HI) begin
      res_o = SMAX;
      sat_o = 1'b1;
    end else if ($signed(a_i) <= LO) begin
      res_o = SMIN;
      sat_o = 1'b1;
    end else begin
      res_o = {a_i[DW-2:0], 1'b0};
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/sat_width.sv
module sat_width #(
  parameter int DW = 32,
  parameter int RW = 32,
  parameter int SW = 5
) (
  input  logic [DW-1:0] val_i,
  input  logic [SW-1:0] shift_i,
  input  logic          uns_i,
  output logic [RW-1:0] res_o,
  output logic          sat_o
);
  logic [DW-1:0]        mask;
  logic signed [DW-1:0] top;

  assign mask = (DW'(1) << shift_i) - DW'(1);
  assign top  = $signed(val_i) >>> shift_i;

  always_comb begin
    res_o = RW'(val_i);
    sat_o = 1'b0;
    if (uns_i) begin
      if (val_i[DW-1]) begin
        res_o = '0;
        sat_o = 1'b1;
      end else if (val_i > mask) begin
        res_o = RW'(mask);
        sat_o = 1'b1;
      end
    end else begin
      if (top > 0) begin
        res_o = RW'(mask);
        sat_o = 1'b1;
      end else if (top < -1) begin
        res_o = RW'(~mask);
        sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      clr_i,
  input  logic [3:0]                op_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  input  logic [$clog2(DATA_W)-1:0] shift_i,
  output logic [DATA_W-1:0]         res_o,
  output logic                      flag_o
);
  import sat_pkg::*;

  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int LANE_W  = DATA_W / LANES;
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  sat_op_e op;
  assign op = sat_op_e'(op_i);

  logic [DATA_W-1:0] as_res, dbl_res, wd_res, lane_res, res_d;
  logic              as_sat, dbl_sat, wd_sat, sat_d;
  logic [LANES-1:0]  lane_sat;
  logic              as_sub, as_uns, as_clamp, wd_uns;

  assign as_sub   = (op == OP_SUB_SAT) || (op == OP_USUB_SAT);
  assign as_uns   = (op == OP_UADD_SAT) || (op == OP_USUB_SAT);
  assign as_clamp = (op != OP_ADD_FLAG);
  assign wd_uns   = (op == OP_UCLAMP) || (op == OP_UCLAMP2);

  sat_addsub #(.DW(DATA_W)) u_as (
    .a_i(a_i), .b_i(b_i), .sub_i(as_sub), .uns_i(as_uns), .clamp_i(as_clamp),
    .res_o(as_res), .sat_o(as_sat)
  );

  sat_double #(.DW(DATA_W)) u_dbl (
    .a_i(a_i), .res_o(dbl_res), .sat_o(dbl_sat)
  );

  sat_width #(.DW(DATA_W), .RW(DATA_W), .SW(SHIFT_W)) u_wd (
    .val_i(a_i), .shift_i(shift_i), .uns_i(wd_uns),
    .res_o(wd_res), .sat_o(wd_sat)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_ext;
    assign lane_ext = {{(DATA_W-LANE_W){a_i[LANE_W*g+LANE_W-1]}}, a_i[LANE_W*g +: LANE_W]};
    sat_width #(.DW(DATA_W), .RW(LANE_W), .SW(SHIFT_W)) u_lw (
      .val_i(lane_ext), .shift_i(shift_i), .uns_i(wd_uns),
      .res_o(lane_res[LANE_W*g +: LANE_W]), .sat_o(lane_sat[g])
    );
  end

  always_comb begin
    unique case (op)
      OP_ADD_FLAG, OP_ADD_SAT, OP_SUB_SAT, OP_UADD_SAT, OP_USUB_SAT: begin
        res_d = as_res;  sat_d = as_sat;
      end
      OP_DBL_SAT:            begin res_d = dbl_res;  sat_d = dbl_sat;     end
      OP_SCLAMP, OP_UCLAMP:  begin res_d = wd_res;   sat_d = wd_sat;      end
      OP_SCLAMP2, OP_UCLAMP2: begin res_d = lane_res; sat_d = |lane_sat;  end
      default:               begin res_d = '0;       sat_d = 1'b0;        end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (valid_i) res_o <= res_d;
      // set has priority over clear
      if (valid_i && sat_d) flag_o <= 1'b1;
      else if (clr_i)       flag_o <= 1'b0;
    end
  end

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  a_r9_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sat_d) |=> flag_o);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(valid_i && sat_d)) |=> !flag_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));

  a_r3_clamp_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && as_sat && (op == OP_ADD_SAT || op == OP_SUB_SAT))
      |=> (res_o == SMAX || res_o == SMIN));

  a_r5_usub_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && as_sat && op == OP_USUB_SAT) |=> (res_o == '0));

  a_r12_unused_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd9) |=> (res_o == '0));
endmodule

// File: tb/sim_sat_alu.sv
module sim_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, clr = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  sh = '0;
  logic [31:0] res;
  logic        flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_res = '0;
  logic        exp_flag = 1'b0;

  always #2 clk = ~clk;

  sat_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clr_i(clr), .op_i(op),
    .a_i(a), .b_i(b), .shift_i(sh), .res_o(res), .flag_o(flag)
  );

  function automatic string op_req(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      default: return "R12";
    endcase
  endfunction

  function automatic void clamp_val(input longint v, input int s, input bit uns,
                                    output longint r, output bit st);
    longint lim = longint'(1) << s;
    r = v; st = 0;
    if (uns) begin
      if (v < 0) begin r = 0; st = 1; end
      else if (v > lim - 1) begin r = lim - 1; st = 1; end
    end else begin
      if (v > lim - 1) begin r = lim - 1; st = 1; end
      else if (v < -lim) begin r = -lim; st = 1; end
    end
  endfunction

  function automatic void model(input logic [3:0] o, input logic [31:0] x, y,
                                input logic [4:0] s, output logic [31:0] r, output bit st);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'({32'd0, x});
    longint uy = longint'({32'd0, y});
    longint t, rl, rh;
    bit sl, shb;
    r = '0; st = 0;
    case (o)
      4'd0: begin t = sx + sy; r = 32'(t); st = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd1, 4'd2: begin
        t = (o == 4'd1) ? sx + sy : sx - sy;
        if (t > 64'sd2147483647) begin r = 32'h7fffffff; st = 1; end
        else if (t < -64'sd2147483648) begin r = 32'h80000000; st = 1; end
        else r = 32'(t);
      end
      4'd3: begin
        if (sx >= 64'sd1073741824) begin r = 32'h7fffffff; st = 1; end
        else if (sx <= -64'sd1073741824) begin r = 32'h80000000; st = 1; end
        else r = 32'(sx * 2);
      end
      4'd4: begin t = ux + uy; if (t > 64'hffffffff) begin r = '1; st = 1; end else r = 32'(t); end
      4'd5: begin if (uy > ux) begin r = '0; st = 1; end else r = 32'(ux - uy); end
      4'd6, 4'd7: begin clamp_val(sx, int'(s), o == 4'd7, t, st); r = 32'(t); end
      4'd8, 4'd9: begin
        clamp_val(longint'($signed(x[15:0])), int'(s), o == 4'd9, rl, sl);
        clamp_val(longint'($signed(x[31:16])), int'(s), o == 4'd9, rh, shb);
        r = {16'(rh), 16'(rl)}; st = sl | shb;
      end
      default: begin r = '0; st = 0; end
    endcase
  endfunction

  task automatic check32(input logic [31:0] act, exp_v, input string tag);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s res act=%08h exp=%08h", tag, act, exp_v);
    end
  endtask

  task automatic check1(input logic act, exp_v, input string tag);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s flag act=%0b exp=%0b", tag, act, exp_v);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input logic v, c, input logic [3:0] o, input logic [31:0] x, y,
                      input logic [4:0] s, input string tag);
    logic [31:0] r;
    bit st;
    model(o, x, y, s, r, st);
    valid = v; clr = c; op = o; a = x; b = y; sh = s;
    @(negedge clk);
    if (v) begin
      exp_res = r;
      exp_flag = st ? 1'b1 : (c ? 1'b0 : exp_flag);
    end else begin
      exp_flag = c ? 1'b0 : exp_flag;
    end
    valid = 1'b0; clr = 1'b0;
    check32(res, exp_res, tag);
    check1(flag, exp_flag, tag);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'h40000000 + $urandom_range(0, 2) - 1;
      3: return 32'hc0000000 + $urandom_range(0, 2) - 1;
      4: return 32'hffffffff;
      5: return 32'($urandom_range(0, 600)) - 32'd300;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check32(res, 32'h0, "R1");
    check1(flag, 1'b0, "R1");

    step(1, 0, 4'd0, 32'h7fffffff, 32'd1, 5'd0, "R2");
    step(0, 1, 4'd0, 32'h0, 32'h0, 5'd0, "R10_R11");
    step(1, 0, 4'd0, 32'd7, 32'hfffffffe, 5'd0, "R2");
    step(1, 0, 4'd1, 32'h7fffffff, 32'd5, 5'd0, "R3");
    step(1, 1, 4'd1, 32'h80000000, 32'hffffffff, 5'd0, "R10");
    step(1, 0, 4'd2, 32'h80000000, 32'd1, 5'd0, "R3");
    step(1, 0, 4'd2, 32'h7fffffff, 32'hffffffff, 5'd0, "R3");
    step(1, 0, 4'd2, 32'd10, 32'd25, 5'd0, "R9");
    step(1, 1, 4'd3, 32'h3fffffff, 32'h0, 5'd0, "R4");
    step(1, 0, 4'd3, 32'hc0000001, 32'h0, 5'd0, "R4");
    step(1, 0, 4'd3, 32'h40000000, 32'h0, 5'd0, "R4");
    step(1, 1, 4'd3, 32'hc0000000, 32'h0, 5'd0, "R4");
    step(0, 1, 4'd0, 32'h0, 32'h0, 5'd0, "R10");
    step(1, 0, 4'd4, 32'hffffffff, 32'd1, 5'd0, "R5");
    step(0, 1, 4'd5, 32'd1, 32'd2, 5'd0, "R11");
    step(1, 0, 4'd5, 32'd5, 32'd3, 5'd0, "R5");
    step(1, 0, 4'd5, 32'd1, 32'd2, 5'd0, "R5");
    step(0, 1, 4'd0, 32'h0, 32'h0, 5'd0, "R10");
    step(1, 0, 4'd6, 32'd100, 32'h0, 5'd7, "R6");
    step(1, 0, 4'd6, 32'd200, 32'h0, 5'd7, "R6");
    step(1, 0, 4'd6, -32'sd300, 32'h0, 5'd7, "R6");
    step(1, 0, 4'd6, 32'd5, 32'h0, 5'd0, "R6");
    step(1, 1, 4'd7, 32'd17, 32'h0, 5'd8, "R7");
    step(1, 0, 4'd7, 32'd300, 32'h0, 5'd8, "R7");
    step(1, 0, 4'd7, 32'hffffffff, 32'h0, 5'd8, "R7");
    step(0, 1, 4'd0, 32'h0, 32'h0, 5'd0, "R10");
    step(1, 0, 4'd8, {16'd500, 16'hfe00}, 32'h0, 5'd7, "R8");
    step(1, 1, 4'd9, 32'h0003_0005, 32'h0, 5'd4, "R8");
    step(1, 0, 4'd9, 32'h0005_8000, 32'h0, 5'd4, "R8");
    step(1, 0, 4'd15, 32'h12345678, 32'h1, 5'd3, "R12");
    step(1, 1, 4'd10, 32'h7fffffff, 32'h7fffffff, 5'd3, "R12");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] o = 4'($urandom_range(0, 10));
      logic v = ($urandom_range(0, 9) != 0);
      logic c = ($urandom_range(0, 19) == 0);
      step(v, c, o, pick(), pick(), 5'($urandom), op_req(o));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule